// File: doc/BRIEF.md
# Programmable System Clock Divider

This block slows down an entire clock region without touching the clock tree. It runs from the fast master clock and produces a single-cycle `tick` strobe. All downstream CPU and peripheral logic uses `tick` as its clock enable. After reset the strobe is high every cycle, so the region runs at the full master rate.

Software programs an 8-bit control word through a plain write port. The top bit turns division on. The low seven bits hold an inverted code `d`, which selects a ratio of `129 - d`.

The code has a write lock. A new ratio can only be loaded by the same write that switches division on from the off state. While division is on, writes that keep the enable bit set are ignored. A write that clears the enable bit always returns to the full rate, and it throws away the code bits that come with it.

Rate changes never take effect in the middle of a period. The strobe counter only picks up the new setting at the next tick. This means no period is ever cut short and no strobes are doubled when the rate changes.

Top module: `sysclk_divider`

## Requirements
- R1: The control word read on `rd_data` holds the enable flag in bit 7 and the stored code `d` in bits 6..0. It changes only on an accepted write, and every write is accepted at once with no handshake.
- R2: While `rst_n` is low, and after reset, the control word reads 0x00 and `tick` is high on every cycle.
- R3: With the enable flag set, `tick` is high exactly once every `129 - d` master cycles: 129 for d = 0, 128 for d = 1, 65 for d = 64 and 2 for d = 127.
- R4: While the enable flag is set, a write with bit 7 = 1 changes neither the control word nor the tick spacing.
- R5: While the enable flag is clear, a write with bit 7 = 1 sets the flag and stores bits 6..0 of that write as the new code.
- R6: A write with bit 7 = 0 clears the enable flag and keeps the previously stored code. Bits 6..0 of that write are discarded.
- R7: While the enable flag is clear, `tick` is high on every cycle.
- R8: A change of enable or ratio takes effect only at a tick. The period that is running when the write lands still lasts its full old length.
- R9: With division active, `tick` is a one-cycle pulse: the cycle after a tick never carries another tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master source clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Control word to write: bit 7 enable, bits 6..0 code |
| rd_data | output | 8 | Control word as currently stored |
| tick | output | 1 | Divided-rate strobe, one master cycle wide |

## Verification
The assertions assume that `wr_en` and `wr_data` are stable around each rising edge and never unknown. They also assume a write lasts a single cycle whenever a particular result is expected, because a held write is simply applied again on each edge.

The bench drives every input on the falling edge and pulses `wr_en` for exactly one cycle. It only asserts `rst_n` on a falling edge, which keeps every sampled input clean. Tick spacing is measured only after the first period following a write, because that first period may still carry the old ratio.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  // Effect of one write on the stored control word
  typedef enum logic [1:0] {
    SDIV_WR_NONE  = 2'd0,
    SDIV_WR_LOAD  = 2'd1,
    SDIV_WR_HOLD  = 2'd2,
    SDIV_WR_CLEAR = 2'd3
  } sdiv_wr_e;

  localparam int unsigned SDIV_CODE_W = 7;
endpackage

// File: rtl/sdiv_rst_sync.sv
module sdiv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
  import sdiv_pkg::*;
#(
  parameter int unsigned CODE_W = SDIV_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W:0]   wr_data,
  output logic              en_q,
  output logic [CODE_W-1:0] code_q
);
  sdiv_wr_e          action;
  logic              en_d;
  logic [CODE_W-1:0] code_d;
  logic              word_ce;

  // Classify the write under the lock rule
  always_comb begin
    action = SDIV_WR_NONE;
    if (wr_en) begin
      if (!wr_data[CODE_W]) action = SDIV_WR_CLEAR;
      else if (en_q)        action = SDIV_WR_HOLD;
      else                  action = SDIV_WR_LOAD;
    end
  end

  always_comb begin
    en_d    = en_q;
    code_d  = code_q;
    word_ce = 1'b0;
    unique case (action)
      SDIV_WR_LOAD: begin
        en_d    = 1'b1;
        code_d  = wr_data[CODE_W-1:0];
        word_ce = 1'b1;
      end
      SDIV_WR_CLEAR: begin
        en_d    = 1'b0;
        word_ce = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      code_q <= '0;
    end else if (word_ce) begin
      en_q   <= en_d;
      code_q <= code_d;
    end
  end
endmodule

// File: rtl/sdiv_counter.sv
module sdiv_counter #(
  parameter int unsigned CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_q,
  input  logic [CODE_W-1:0] code_q,
  output logic              tick
);
  localparam int unsigned CNT_W = CODE_W + 1;
  localparam logic [CNT_W-1:0] TOP_VAL = CNT_W'(2 ** CODE_W);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] reload;

  assign reload = TOP_VAL - {1'b0, code_q};
  assign tick   = (cnt_q == '0);

  // Settings are sampled only at a tick boundary
  always_comb begin
    if (tick) cnt_d = en_q ? reload : '0;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sysclk_divider.sv
module sysclk_divider
  import sdiv_pkg::*;
#(
  parameter int unsigned CODE_W = SDIV_CODE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CODE_W:0] wr_data,
  output logic [CODE_W:0] rd_data,
  output logic            tick
);
  logic              rst_n_sync;
  logic              en_q;
  logic [CODE_W-1:0] code_q;

  sdiv_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  sdiv_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .en_q    (en_q),
    .code_q  (code_q)
  );

  sdiv_counter #(.CODE_W(CODE_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .en_q   (en_q),
    .code_q (code_q),
    .tick   (tick)
  );

  assign rd_data = {en_q, code_q};
endmodule

// File: rtl/sysclk_divider_chk.sv
module sysclk_divider_chk #(
  parameter int unsigned CODE_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [CODE_W:0] wr_data,
  input logic [CODE_W:0] rd_data,
  input logic            tick
);
  // R1
  word_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));

  // R4
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[CODE_W] && rd_data[CODE_W]) |=> $stable(rd_data));

  // R5
  load_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[CODE_W] && !rd_data[CODE_W]) |=> (rd_data == $past(wr_data)));

  // R6
  clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[CODE_W]) |=>
      (!rd_data[CODE_W] && rd_data[CODE_W-1:0] == $past(rd_data[CODE_W-1:0])));

  // R7
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !rd_data[CODE_W]) |=> tick);

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rd_data[CODE_W]) |=> !tick);
endmodule

bind sysclk_divider sysclk_divider_chk #(.CODE_W(CODE_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .tick    (tick)
);

// File: tb/sim_sysclk_divider.sv
`timescale 1ns/1ps
module sim_sysclk_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       tick;

  int checks = 0;
  int failures = 0;
  logic [6:0] model_code = 7'd0;

  always #4 clk = ~clk;

  sysclk_divider u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .tick(tick)
  );

  // {write value, expected spacing}
  localparam logic [15:0] VEC [0:5] = '{
    {8'h80, 8'd129}, {8'h81, 8'd128}, {8'hC0, 8'd65},
    {8'hFF, 8'd2},   {8'h33, 8'd1},   {8'hA5, 8'd92}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  // Cycles from one tick to the next, sampled on falling edges
  task automatic gap(output int n);
    int g;
    g = 0;
    while (!tick && g < 1000) begin @(negedge clk); g++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!tick && n < 1000);
  endtask

  task automatic settled_gap(output int n);
    int tmp;
    gap(tmp);
    gap(n);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    int n;
    int k;
    logic [7:0] exp_word;
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2 rd_data in reset", rd_data, 0);
    check("R2 tick in reset", tick, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 rd_data after reset", rd_data, 0);
    settled_gap(n);
    check("R7 spacing after reset", n, 1);

    // Vector table: R3, R5, R6, R7
    foreach (VEC[i]) begin
      write_word(8'h00);
      write_word(VEC[i][15:8]);
      if (VEC[i][15]) model_code = VEC[i][14:8];
      exp_word = VEC[i][15] ? VEC[i][15:8] : {1'b0, model_code};
      @(negedge clk);
      check("R1 R5 R6 readback", rd_data, exp_word);
      settled_gap(n);
      check(VEC[i][15] ? "R3 spacing" : "R7 spacing", n, VEC[i][7:0]);
    end

    // R4: locked write while enabled
    write_word(8'h00);
    write_word(8'hC0);
    write_word(8'h85);
    @(negedge clk);
    check("R4 readback", rd_data, 8'hC0);
    settled_gap(n);
    check("R4 spacing", n, 65);

    // R6: clear with a code field
    write_word(8'h15);
    @(negedge clk);
    check("R6 readback", rd_data, 8'h40);
    settled_gap(n);
    check("R6 spacing", n, 1);

    // R8: disable mid-period keeps the full old period
    write_word(8'h80);
    settled_gap(n);
    while (!tick) @(negedge clk);
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (k == 10) begin wr_en = 1'b1; wr_data = 8'h00; end
      if (k == 11) begin wr_en = 1'b0; end
    end while (!tick && k < 1000);
    check("R8 period across disable", k, 129);
    gap(n);
    check("R8 R7 spacing after disable", n, 1);

    // R9: shortest ratio never gives back-to-back ticks
    write_word(8'hFF);
    settled_gap(n);
    check("R9 spacing at d=127", n, 2);

    // R2: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R2 rd_data on async reset", rd_data, 0);
    check("R2 tick on async reset", tick, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule